// File: doc/BRIEF.md
# Byte-to-Word Data Port Bridge

This block sits between an 8-bit host bus and the 16-bit data register of an ATA storage device. The host moves a 16-bit word as two byte accesses. Address bit 0 decides which half of the word an access touches: even is the low half and odd is the high half. Address decoding of the data window happens upstream, so any even/odd pair inside the window behaves the same way. Software can therefore stream a whole 512-byte sector as 256 consecutive byte pairs.

One 8-bit staging register serves both directions. On a write, the low byte is parked in it, and the later high-byte write sends the full word to the device in a single device write. On a read, the low-byte access runs one device read, hands the low half to the host and parks the high half. The following high-byte read is answered from the staging register without touching the device. The host must keep the low-then-high order. A high-byte access that comes out of order silently uses whatever the staging register holds.

Each device cycle holds the read or write strobe for a fixed, parameterised number of clocks and ends with a one-clock done pulse. While a device cycle is in flight, the host access is held off with a wait signal. The device's interrupt line is not used; software polls the device status instead.

Top module: `byte_word_bridge`

## Requirements
- R1: A host write with `host_odd`=0 loads `host_wdata` into the staging register and raises no device strobe.
- R2: A host write with `host_odd`=1 runs exactly one device write. `dev_wdata[15:8]` is the host byte and `dev_wdata[7:0]` is the staging register.
- R3: A high-byte write with no low-byte write before it sends the stale staging value as the low half, and no error indication exists. After several low-byte writes, only the last one counts.
- R4: A host read with `host_odd`=0 runs exactly one device read. It returns `dev_rdata[7:0]` on `host_rdata` and loads `dev_rdata[15:8]` into the staging register.
- R5: A host read with `host_odd`=1 returns the staging register on `host_rdata` and raises no device strobe.
- R6: Each device cycle holds exactly one of `dev_rd_stb`/`dev_wr_stb` high for STROBE_CYCLES consecutive clocks. The two strobes are never high together. `dev_done` pulses for one clock right after the strobe drops.
- R7: `host_wait` is high from the first clock of a request until `host_ack`. `host_ack` is a single-clock pulse, and for a device access it coincides with `dev_done`.
- R8: The staging register clears to 0x00 on reset, and after reset all strobes, `host_ack` and `dev_done` are low.
- R9: A stream of N low/high write pairs produces exactly N device writes, each carrying its own pair's bytes (N=256 for one sector).
- R10: The staging register is shared between directions. A high byte staged by a read becomes the low half of a following high-byte write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Byte access request, held until `host_ack` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_odd | input | 1 | Address bit 0: 1 = high half, 0 = low half |
| host_wdata | input | DW | Host write byte |
| host_rdata | output | DW | Host read byte, valid when `host_ack` is high |
| host_wait | output | 1 | Host access stalled |
| host_ack | output | 1 | One-clock completion pulse |
| dev_rd_stb | output | 1 | Device read strobe |
| dev_wr_stb | output | 1 | Device write strobe |
| dev_wdata | output | 2*DW | Word driven to the device during a write |
| dev_rdata | input | 2*DW | Word returned by the device, sampled on the last strobe clock |
| dev_done | output | 1 | One-clock pulse ending a device cycle |

## Verification
Several input patterns drive the main function:
- An ordered low/high write pair tells correct word assembly apart from byte swapping.
- An orphan high-byte write, and repeated low-byte writes, tell stale-latch reuse apart from clearing or merging.
- A low/high read pair checks two things: that only the even access reaches the device, and that the odd access returns the parked byte.
- A read followed by a high-byte write exposes the shared latch.
- A 256-pair sector stream separates one device cycle per pair from any extra or missing cycle.
- Strobe width and the timing of wait, ack and done are measured on every device cycle.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } bwb_state_e;

   typedef enum logic {
      DIR_RD = 1'b0,
      DIR_WR = 1'b1
   } bwb_dir_e;
endpackage

// File: rtl/bwb_stage_latch.sv
module bwb_stage_latch #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_host,
   input  logic [DW-1:0] host_byte,
   input  logic          load_dev,
   input  logic [DW-1:0] dev_byte,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)         q <= '0;
      else if (load_host) q <= host_byte;
      else if (load_dev)  q <= dev_byte;
   end

   // R10: host and device never load the shared latch in the same clock
   assert_single_loader_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_host && load_dev));
endmodule

// File: rtl/bwb_dev_timer.sv
module bwb_dev_timer
   import bwb_pkg::*;
#(
   parameter int STROBE_CYCLES = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  bwb_dir_e dir,
   output logic     rd_stb,
   output logic     wr_stb,
   output logic     fin,
   output logic     done
);
   localparam int CW = (STROBE_CYCLES < 2) ? 1 : $clog2(STROBE_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(STROBE_CYCLES - 1);

   generate
      if (STROBE_CYCLES < 1) begin : g_bad_len
         $error("STROBE_CYCLES must be at least 1");
      end
   endgenerate

   logic          active;
   logic [CW-1:0] cnt;
   bwb_dir_e      dir_q;

   assign fin    = active && (cnt == LAST);
   assign rd_stb = active && (dir_q == DIR_RD);
   assign wr_stb = active && (dir_q == DIR_WR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         dir_q  <= DIR_RD;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !active) begin
            active <= 1'b1;
            cnt    <= '0;
            dir_q  <= dir;
         end else if (active) begin
            if (cnt == LAST) begin
               active <= 1'b0;
               done   <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R6: strobes are mutually exclusive
   assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb && wr_stb));
   // R6: done follows directly on a strobe that has just dropped
   assert_done_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!rd_stb && !wr_stb && $past(rd_stb || wr_stb)));
   // R6: a start never arrives while a cycle is already running
   assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !active);
endmodule

// File: rtl/bwb_host_ctrl.sv
module bwb_host_ctrl
   import bwb_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            host_req,
   input  logic            host_we,
   input  logic            host_odd,
   input  logic [DW-1:0]   host_wdata,
   output logic [DW-1:0]   host_rdata,
   output logic            host_ack,
   input  logic [DW-1:0]   latch_q,
   output logic            load_host,
   output logic            load_dev,
   output logic [DW-1:0]   dev_byte,
   output logic            start,
   output bwb_dir_e        dir,
   input  logic            fin,
   input  logic [2*DW-1:0] dev_rdata,
   output logic [2*DW-1:0] dev_wdata
);
   bwb_state_e state;
   bwb_dir_e   run_dir;
   logic       idle_req;
   logic       need_dev;

   assign idle_req  = (state == ST_IDLE) && host_req;
   assign need_dev  = host_we ? host_odd : !host_odd;
   assign start     = idle_req && need_dev;
   assign dir       = host_we ? DIR_WR : DIR_RD;
   assign load_host = idle_req && host_we && !host_odd;
   assign load_dev  = (state == ST_RUN) && fin && (run_dir == DIR_RD);
   assign dev_byte  = dev_rdata[2*DW-1:DW];
   assign host_ack  = (state == ST_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         run_dir    <= DIR_RD;
         host_rdata <= '0;
         dev_wdata  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (host_req) begin
                  if (start) begin
                     state   <= ST_RUN;
                     run_dir <= dir;
                     if (host_we) dev_wdata <= {host_wdata, latch_q};
                  end else begin
                     state <= ST_DONE;
                     if (!host_we) host_rdata <= latch_q;
                  end
               end
            end
            ST_RUN: begin
               if (fin) begin
                  state <= ST_DONE;
                  if (run_dir == DIR_RD) host_rdata <= dev_rdata[DW-1:0];
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R7: completion is a single-clock pulse
   assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |=> !host_ack);
   // R1 / R5: device cycles start only for an odd write or an even read
   assert_dev_kind_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (host_we == host_odd));
   // R5: an odd read is answered from the latch on the next clock
   assert_odd_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_req && !host_we && host_odd) |=> (host_ack && host_rdata == $past(latch_q)));
endmodule

// File: rtl/byte_word_bridge.sv
module byte_word_bridge
   import bwb_pkg::*;
#(
   parameter int DW            = 8,
   parameter int STROBE_CYCLES = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            host_req,
   input  logic            host_we,
   input  logic            host_odd,
   input  logic [DW-1:0]   host_wdata,
   output logic [DW-1:0]   host_rdata,
   output logic            host_wait,
   output logic            host_ack,
   output logic            dev_rd_stb,
   output logic            dev_wr_stb,
   output logic [2*DW-1:0] dev_wdata,
   input  logic [2*DW-1:0] dev_rdata,
   output logic            dev_done
);
   generate
      if (DW < 1) begin : g_bad_dw
         $error("DW must be at least 1");
      end
   endgenerate

   logic          load_host, load_dev, start, fin;
   logic [DW-1:0] latch_q, dev_byte;
   bwb_dir_e      dir;

   bwb_stage_latch #(.DW(DW)) u_latch (
      .clk(clk), .rst_n(rst_n),
      .load_host(load_host), .host_byte(host_wdata),
      .load_dev(load_dev), .dev_byte(dev_byte),
      .q(latch_q)
   );

   bwb_dev_timer #(.STROBE_CYCLES(STROBE_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .start(start), .dir(dir),
      .rd_stb(dev_rd_stb), .wr_stb(dev_wr_stb),
      .fin(fin), .done(dev_done)
   );

   bwb_host_ctrl #(.DW(DW)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_odd(host_odd),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ack(host_ack),
      .latch_q(latch_q), .load_host(load_host), .load_dev(load_dev),
      .dev_byte(dev_byte), .start(start), .dir(dir), .fin(fin),
      .dev_rdata(dev_rdata), .dev_wdata(dev_wdata)
   );

   assign host_wait = host_req && !host_ack;

   // R7: the host is held off for the whole device cycle
   assert_wait_in_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_rd_stb || dev_wr_stb) |-> host_wait);
   // R7: device completion and host completion coincide
   assert_done_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dev_done |-> host_ack);
endmodule

// File: tb/tb_byte_word_bridge.sv
`timescale 1ns/1ps
module tb_byte_word_bridge;
   localparam int DW = 8;
   localparam int SC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0, host_odd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        host_wait, host_ack, dev_rd_stb, dev_wr_stb, dev_done;
   logic [15:0] dev_wdata;
   logic [15:0] dev_rdata = '0;

   always #2.5 clk = ~clk;

   byte_word_bridge #(.DW(DW), .STROBE_CYCLES(SC)) dut (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_odd(host_odd),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_wait(host_wait), .host_ack(host_ack),
      .dev_rd_stb(dev_rd_stb), .dev_wr_stb(dev_wr_stb),
      .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_done(dev_done)
   );

   int checks = 0, fails = 0;
   int rd_cycles = 0, wr_cycles = 0, done_cnt = 0, run = 0, last_len = 0, bad_len = 0;
   logic [15:0] last_wr = '0, wr_xor = '0;
   logic prev_stb = 1'b0;

   // device-side monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (dev_done) done_cnt++;
      if (dev_rd_stb || dev_wr_stb) begin
         if (!prev_stb) begin
            if (dev_wr_stb) begin
               wr_cycles++;
               last_wr = dev_wdata;
               wr_xor  = wr_xor ^ dev_wdata;
            end else rd_cycles++;
         end
         run++;
      end else if (run > 0) begin
         last_len = run;
         if (run != SC) bad_len++;
         run = 0;
      end
      prev_stb = dev_rd_stb || dev_wr_stb;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(input logic we, input logic odd, input logic [7:0] wd,
                         output logic [7:0] rd, output int wait_seen);
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_odd = odd; host_wdata = wd;
      wait_seen = 0;
      #0.1;
      if (host_wait) wait_seen = 1;
      do begin
         @(negedge clk);
      end while (!host_ack);
      rd = host_rdata;
      host_req = 1'b0;
   endtask

   // vector: we, odd, wdata, device word, expected rdata, expected write word, kind(0 none,1 rd,2 wr)
   typedef struct packed {
      logic        we;
      logic        odd;
      logic [7:0]  wd;
      logic [15:0] dword;
      logic [7:0]  exp_rd;
      logic [15:0] exp_wr;
      logic [1:0]  kind;
   } vec_t;
   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b1, 8'h00, 16'h0000, 8'h00, 16'h0000, 2'd0}, // R8 R5 latch zero after reset
      '{1'b1, 1'b0, 8'h34, 16'h0000, 8'h00, 16'h0000, 2'd0}, // R1 stage low
      '{1'b1, 1'b1, 8'h12, 16'h0000, 8'h00, 16'h1234, 2'd2}, // R2 word write
      '{1'b1, 1'b1, 8'hAB, 16'h0000, 8'h00, 16'hAB34, 2'd2}, // R3 stale low
      '{1'b0, 1'b0, 8'h00, 16'hBEEF, 8'hEF, 16'h0000, 2'd1}, // R4 word read
      '{1'b0, 1'b1, 8'h00, 16'h1111, 8'hBE, 16'h0000, 2'd0}, // R5 staged high
      '{1'b1, 1'b1, 8'h55, 16'h0000, 8'h00, 16'h55BE, 2'd2}, // R10 shared latch
      '{1'b1, 1'b0, 8'h01, 16'h0000, 8'h00, 16'h0000, 2'd0}, // R3 first low
      '{1'b1, 1'b0, 8'h02, 16'h0000, 8'h00, 16'h0000, 2'd0}, // R3 second low wins
      '{1'b1, 1'b1, 8'h03, 16'h0000, 8'h00, 16'h0302, 2'd2}  // R3 last low used
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin : main
      logic [7:0] rd;
      int ws, r0, w0, d0;
      logic [15:0] exp_xor;

      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8: idle outputs after reset
      check("R8 strobes idle", {30'd0, dev_rd_stb, dev_wr_stb}, 32'd0);
      check("R8 ack/done idle", {30'd0, host_ack, dev_done}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         r0 = rd_cycles; w0 = wr_cycles;
         dev_rdata = VECS[i].dword;
         access(VECS[i].we, VECS[i].odd, VECS[i].wd, rd, ws);
         @(negedge clk);
         if (VECS[i].kind == 2'd0) begin
            check("R1/R5 no device cycle", rd_cycles + wr_cycles - r0 - w0, 0);
         end else if (VECS[i].kind == 2'd1) begin
            check("R4 one device read", rd_cycles - r0, 1);
            check("R4 no device write", wr_cycles - w0, 0);
         end else begin
            check("R2 one device write", wr_cycles - w0, 1);
            check("R2/R3/R10 write word", {16'd0, last_wr}, {16'd0, VECS[i].exp_wr});
         end
         if (!VECS[i].we) check("R4/R5/R8 read byte", {24'd0, rd}, {24'd0, VECS[i].exp_rd});
      end

      // R6: strobe width and done pulse
      check("R6 strobe width", last_len, SC);
      check("R6 done count", done_cnt, rd_cycles + wr_cycles);

      // R7: wait high from first clock of a device access, and for a local access
      access(1'b0, 1'b0, 8'h00, rd, ws);
      check("R7 wait on device read", ws, 1);
      access(1'b1, 1'b0, 8'h77, rd, ws);
      check("R7 wait on staging write", ws, 1);
      @(negedge clk);
      check("R7 wait released", {31'd0, host_wait}, 32'd0);

      // R9: one sector as 256 write pairs
      w0 = wr_cycles; wr_xor = '0; exp_xor = '0;
      for (int k = 0; k < 256; k++) begin
         logic [15:0] wv;
         wv = 16'(k * 16'h0101 ^ 16'h5A3C);
         exp_xor = exp_xor ^ wv;
         access(1'b1, 1'b0, wv[7:0], rd, ws);
         access(1'b1, 1'b1, wv[15:8], rd, ws);
      end
      @(negedge clk);
      check("R9 sector write count", wr_cycles - w0, 256);
      check("R9 sector data xor", {16'd0, wr_xor}, {16'd0, exp_xor});
      check("R6 all strobes full width", bad_len, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule